// File: doc/BRIEF.md
# Memory Access Fault Checker with Bus Status Capture

This block sits beside the memory decoder and judges every access from the processor or from the DMA engine in the cycle it is presented. It receives the address, direction, size, privilege level and source of the access, together with the page-state and write-enable bits of the page's translation entry, and sorts the access into one of five outcomes: allowed, page fault, user access to the I/O region, user access to kernel space, or write to a protected page. Faulting accesses are blocked at once. A faulting write never reaches memory, and a faulting read returns all ones.

When an access faults, three 16-bit status words are loaded on the next clock edge. The general status word carries a code for the cause, the source, the direction and the parity-interrupt setting. The first bus status word carries the byte-lane and size, the source, and the upper address byte. The second bus status word holds the low address half. Processor faults raise a bus-error pulse and DMA faults raise a level-7 interrupt pulse, but only while errors are enabled. A clear-status strobe returns all three words to their idle value. Software reads the words back through a select input.

Top module: `bus_fault_monitor`

## Requirements
- R1: After reset all three status words read 0xFFFF, and `bus_err_o` and `nmi_o` are low.
- R2: An address below 0x400000 (the RAM region) whose page state `map_state_i` is 0 gives cause 1 (page fault), at both privilege levels. At or above 0x400000 the page state is ignored.
- R3: A supervisor access that is not a page fault is allowed (cause 0), whatever its address or write-enable bit.
- R4: For a user access that is not a page fault, the checks apply in this order: an address at or above 0x400000 gives cause 2; otherwise address bits 22:19 all zero give cause 3; otherwise a write with `map_we_i` low gives cause 4; otherwise cause 0.
- R5: On a fault the general status word loads a base code. For the processor, a page fault gives 0x8BFF, cause 2 gives 0x9AFF, and causes 3 and 4 give 0x9BFF. For DMA the codes are 0xABFF, 0xBAFF and 0xBBFF. A read ORs in 0x4000, and `par_irq_en_i` high ORs in 0x0400.
- R6: On a fault bus status word 0 loads a base value ORed with address bits 23:16. For DMA the base is 0x3C00. For the processor it is 0x7C00 for word or long size, and for byte size it is 0x7E00 at an odd address or 0x7D00 at an even one. Size encoding: 0 byte, 1 word, 2 long.
- R7: On a fault bus status word 1 loads address bits 15:0.
- R8: The clock edge that captures a processor fault while `err_en_i` is high drives `bus_err_o` high for one cycle. A DMA fault drives `nmi_o` high in the same way. With `err_en_i` low neither output rises, but the status words still load.
- R9: `clr_stat_i` sets all three words to 0xFFFF on the next edge. If a fault occurs in the same cycle, the fault values are loaded instead.
- R10: A faulting access holds `mem_we_o` low and forces `cpu_rdata_o` to all ones. An allowed write drives `mem_we_o` high, and an allowed read passes `mem_rdata_i` through.
- R11: `rd_data_o` shows the general status word when `rd_sel_i` is 0, bus status 0 when it is 1, bus status 1 when it is 2, and 0xFFFF when it is 3.
- R12: An allowed access, or a cycle with `acc_valid_i` low, leaves the status words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_addr_i | input | 24 | Logical byte address |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_size_i | input | 2 | 0 byte, 1 word, 2 long |
| acc_super_i | input | 1 | Access at supervisor privilege |
| acc_dma_i | input | 1 | Access issued by the DMA engine |
| map_state_i | input | 2 | Page state from the translation entry, 0 = absent |
| map_we_i | input | 1 | Write-enable bit of the translation entry |
| err_en_i | input | 1 | Enables the bus-error and interrupt outputs |
| par_irq_en_i | input | 1 | Parity-interrupt enable, reflected in the status code |
| clr_stat_i | input | 1 | Clear-status strobe |
| mem_rdata_i | input | 32 | Read data from memory |
| rd_sel_i | input | 2 | Selects the status word for readback |
| acc_fault_o | output | 1 | Presented access faults |
| cause_o | output | 3 | Cause code 0..4 |
| mem_we_o | output | 1 | Write strobe passed to memory |
| cpu_rdata_o | output | 32 | Read data returned to the requester |
| bus_err_o | output | 1 | Bus-error pulse to the processor |
| nmi_o | output | 1 | Level-7 interrupt pulse for DMA faults |
| rd_data_o | output | 16 | Selected status word |

## Verification
A clear-status strobe and a faulting access can both arrive on one clock edge. Each of them writes the same three status words. The bench presents faulting accesses, harmless accesses and idle cycles together with the strobe. It then reads every word back and compares it with a software model, in which a fault takes precedence over the clear. A sweep over addresses, page states, privilege levels, direction, source, size and the two enables checks the cause and all three encoded words after every access.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  typedef enum logic [2:0] {
    CAUSE_OK    = 3'd0,
    CAUSE_PAGE  = 3'd1,
    CAUSE_UIO   = 3'd2,
    CAUSE_KERN  = 3'd3,
    CAUSE_WPROT = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } size_e;

  localparam int STAT_W = 16;
  localparam int NUM_STAT = 3;
  localparam logic [STAT_W-1:0] STAT_IDLE = 16'hFFFF;

  // general status composition
  localparam logic [STAT_W-1:0] GS_BASE     = 16'h8AFF;
  localparam logic [STAT_W-1:0] GS_NOT_UIO  = 16'h0100;
  localparam logic [STAT_W-1:0] GS_NOT_PAGE = 16'h1000;
  localparam logic [STAT_W-1:0] GS_DMA      = 16'h2000;
  localparam logic [STAT_W-1:0] GS_READ     = 16'h4000;
  localparam logic [STAT_W-1:0] GS_PIE      = 16'h0400;

  localparam logic [STAT_W-1:0] BS0_DMA  = 16'h3C00;
  localparam logic [STAT_W-1:0] BS0_WIDE = 16'h7C00;
  localparam logic [STAT_W-1:0] BS0_ODD  = 16'h7E00;
  localparam logic [STAT_W-1:0] BS0_EVEN = 16'h7D00;
endpackage

// File: rtl/bfm_classify.sv
module bfm_classify
  import bfm_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int RAM_TOP = 32'h0040_0000,
  parameter int KERN_LO = 19,
  parameter int KERN_HI = 22
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              super_i,
  input  logic [1:0]        state_i,
  input  logic              we_i,
  output cause_e            cause_o
);
  localparam logic [ADDR_W-1:0] RAM_LIMIT = ADDR_W'(RAM_TOP);

  logic in_ram;
  logic kern_hit;

  assign in_ram   = addr_i < RAM_LIMIT;
  assign kern_hit = addr_i[KERN_HI:KERN_LO] == '0;

  always_comb begin
    if (in_ram && state_i == 2'd0)     cause_o = CAUSE_PAGE;
    else if (super_i)                  cause_o = CAUSE_OK;
    else if (!in_ram)                  cause_o = CAUSE_UIO;
    else if (kern_hit)                 cause_o = CAUSE_KERN;
    else if (write_i && !we_i)         cause_o = CAUSE_WPROT;
    else                               cause_o = CAUSE_OK;
  end
endmodule

// File: rtl/bfm_encode.sv
module bfm_encode
  import bfm_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  cause_e                    cause_i,
  input  logic                      dma_i,
  input  logic                      write_i,
  input  logic                      pie_i,
  input  logic [1:0]                size_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic [NUM_STAT-1:0][STAT_W-1:0] word_o
);
  localparam int HI_W = ADDR_W - 16;

  logic [STAT_W-1:0] gs;
  logic [STAT_W-1:0] bs0_base;

  always_comb begin
    gs = GS_BASE;
    if (cause_i != CAUSE_UIO)  gs = gs | GS_NOT_UIO;
    if (cause_i != CAUSE_PAGE) gs = gs | GS_NOT_PAGE;
    if (dma_i)                 gs = gs | GS_DMA;
    if (!write_i)              gs = gs | GS_READ;
    if (pie_i)                 gs = gs | GS_PIE;
  end

  always_comb begin
    if (dma_i)                          bs0_base = BS0_DMA;
    else if (size_e'(size_i) != SZ_BYTE) bs0_base = BS0_WIDE;
    else if (addr_i[0])                 bs0_base = BS0_ODD;
    else                                bs0_base = BS0_EVEN;
  end

  assign word_o[0] = gs;
  assign word_o[1] = bs0_base | STAT_W'({{(16 - HI_W){1'b0}}, addr_i[ADDR_W-1:16]});
  assign word_o[2] = addr_i[15:0];
endmodule

// File: rtl/bfm_status.sv
module bfm_status
  import bfm_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cap_i,
  input  logic                            clr_i,
  input  logic [NUM_STAT-1:0][STAT_W-1:0] word_i,
  input  logic [1:0]                      sel_i,
  output logic [NUM_STAT-1:0][STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0]               rd_o
);
  for (genvar g = 0; g < NUM_STAT; g++) begin : g_word
    logic [STAT_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= STAT_IDLE;
      else if (cap_i) q <= word_i[g];   // capture outranks clear
      else if (clr_i) q <= STAT_IDLE;
    end
    assign stat_o[g] = q;
  end

  always_comb begin
    if (int'(sel_i) < NUM_STAT) rd_o = stat_o[sel_i];
    else                        rd_o = STAT_IDLE;
  end
endmodule

// File: rtl/bus_fault_monitor.sv
module bus_fault_monitor
  import bfm_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int RAM_TOP = 32'h0040_0000,
  parameter int KERN_LO = 19,
  parameter int KERN_HI = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic [1:0]        acc_size_i,
  input  logic              acc_super_i,
  input  logic              acc_dma_i,
  input  logic [1:0]        map_state_i,
  input  logic              map_we_i,
  input  logic              err_en_i,
  input  logic              par_irq_en_i,
  input  logic              clr_stat_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [1:0]        rd_sel_i,
  output logic              acc_fault_o,
  output logic [2:0]        cause_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_err_o,
  output logic              nmi_o,
  output logic [15:0]       rd_data_o
);
  cause_e                            cause;
  logic                              fault;
  logic [NUM_STAT-1:0][STAT_W-1:0]   enc_w;
  logic [NUM_STAT-1:0][STAT_W-1:0]   stat_w;
  logic                              bus_err_q;
  logic                              nmi_q;

  bfm_classify #(
    .ADDR_W (ADDR_W),
    .RAM_TOP(RAM_TOP),
    .KERN_LO(KERN_LO),
    .KERN_HI(KERN_HI)
  ) u_classify (
    .addr_i (acc_addr_i),
    .write_i(acc_write_i),
    .super_i(acc_super_i),
    .state_i(map_state_i),
    .we_i   (map_we_i),
    .cause_o(cause)
  );

  bfm_encode #(.ADDR_W(ADDR_W)) u_encode (
    .cause_i(cause),
    .dma_i  (acc_dma_i),
    .write_i(acc_write_i),
    .pie_i  (par_irq_en_i),
    .size_i (acc_size_i),
    .addr_i (acc_addr_i),
    .word_o (enc_w)
  );

  assign fault = acc_valid_i && (cause != CAUSE_OK);

  bfm_status u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (fault),
    .clr_i (clr_stat_i),
    .word_i(enc_w),
    .sel_i (rd_sel_i),
    .stat_o(stat_w),
    .rd_o  (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_err_q <= 1'b0;
      nmi_q     <= 1'b0;
    end else begin
      bus_err_q <= fault && err_en_i && !acc_dma_i;
      nmi_q     <= fault && err_en_i && acc_dma_i;
    end
  end

  assign acc_fault_o = fault;
  assign cause_o     = cause;
  assign mem_we_o    = acc_valid_i && acc_write_i && !fault;
  assign cpu_rdata_o = (fault && !acc_write_i) ? '1 : mem_rdata_i;
  assign bus_err_o   = bus_err_q;
  assign nmi_o       = nmi_q;
endmodule

// File: rtl/bfm_checker.sv
module bfm_checker (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic [15:0]      addr_lo_i,
  input logic             acc_write_i,
  input logic             acc_super_i,
  input logic             acc_dma_i,
  input logic [1:0]       map_state_i,
  input logic             err_en_i,
  input logic             clr_stat_i,
  input logic             acc_fault_o,
  input logic             mem_we_o,
  input logic [31:0]      cpu_rdata_o,
  input logic             bus_err_o,
  input logic             nmi_o,
  input logic [2:0][15:0] stat_i
);
  a_r3_super_allowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_super_i && map_state_i != 2'd0 |-> !acc_fault_o);

  a_r7_addr_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_fault_o |=> stat_i[2] == $past(addr_lo_i));

  a_r8_bus_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_fault_o && err_en_i && !acc_dma_i |=> bus_err_o && !nmi_o);

  a_r8_nmi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_fault_o && err_en_i && acc_dma_i |=> nmi_o && !bus_err_o);

  a_r8_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_en_i |=> !bus_err_o && !nmi_o);

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_stat_i && !acc_fault_o |=> stat_i[0] == 16'hFFFF && stat_i[1] == 16'hFFFF
                                   && stat_i[2] == 16'hFFFF);

  a_r10_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_fault_o |-> !mem_we_o);

  a_r10_read_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_fault_o && !acc_write_i |-> cpu_rdata_o == 32'hFFFF_FFFF);

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_fault_o && !clr_stat_i |=> $stable(stat_i));

  a_r12_idle_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !acc_fault_o);
endmodule

bind bus_fault_monitor bfm_checker chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_valid_i(acc_valid_i),
  .addr_lo_i  (acc_addr_i[15:0]),
  .acc_write_i(acc_write_i),
  .acc_super_i(acc_super_i),
  .acc_dma_i  (acc_dma_i),
  .map_state_i(map_state_i),
  .err_en_i   (err_en_i),
  .clr_stat_i (clr_stat_i),
  .acc_fault_o(acc_fault_o),
  .mem_we_o   (mem_we_o),
  .cpu_rdata_o(cpu_rdata_o),
  .bus_err_o  (bus_err_o),
  .nmi_o      (nmi_o),
  .stat_i     (stat_w)
);

// File: tb/bus_fault_monitor_tb_top.sv
`timescale 1ns/1ps
module bus_fault_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0, sup = 1'b0, dma = 1'b0, we = 1'b0;
  logic        een = 1'b0, pie = 1'b0, clr = 1'b0;
  logic [23:0] addr = '0;
  logic [1:0]  size = '0, st = '0, sel = '0;
  logic [31:0] mrd = '0;
  logic        fault_o, mwe_o, berr_o, nmi_o;
  logic [2:0]  cause_o;
  logic [31:0] crd_o;
  logic [15:0] rd_o;

  int checks = 0, fails = 0;
  logic [15:0] m_gs = 16'hFFFF, m_b0 = 16'hFFFF, m_b1 = 16'hFFFF;

  always #10 clk = ~clk;

  bus_fault_monitor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_addr_i(addr),
    .acc_write_i(wr), .acc_size_i(size), .acc_super_i(sup), .acc_dma_i(dma),
    .map_state_i(st), .map_we_i(we), .err_en_i(een), .par_irq_en_i(pie),
    .clr_stat_i(clr), .mem_rdata_i(mrd), .rd_sel_i(sel), .acc_fault_o(fault_o),
    .cause_o(cause_o), .mem_we_o(mwe_o), .cpu_rdata_o(crd_o), .bus_err_o(berr_o),
    .nmi_o(nmi_o), .rd_data_o(rd_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_cause(input logic [23:0] a, input logic [1:0] s,
                                           input logic w, input logic su, input logic e);
    if (a < 24'h400000 && s == 2'd0) return 3'd1;   // R2
    if (su) return 3'd0;                            // R3
    if (a >= 24'h400000) return 3'd2;               // R4
    if (a[22:19] == 4'd0) return 3'd3;
    if (w && !e) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [15:0] ref_gs(input logic [2:0] c, input logic d,
                                         input logic w, input logic p);
    logic [15:0] v;
    case (c)
      3'd1:    v = d ? 16'hABFF : 16'h8BFF;
      3'd2:    v = d ? 16'hBAFF : 16'h9AFF;
      default: v = d ? 16'hBBFF : 16'h9BFF;
    endcase
    if (!w) v |= 16'h4000;
    if (p)  v |= 16'h0400;
    return v;
  endfunction

  function automatic logic [15:0] ref_b0(input logic d, input logic [1:0] sz, input logic [23:0] a);
    logic [15:0] v;
    if (d) v = 16'h3C00;
    else if (sz != 2'd0) v = 16'h7C00;
    else v = a[0] ? 16'h7E00 : 16'h7D00;
    return v | {8'h00, a[23:16]};
  endfunction

  task automatic read_back(input string tag);
    sel = 2'd0; #1 chk({tag, " R11 gs"},  {16'h0, rd_o}, {16'h0, m_gs});
    sel = 2'd1; #1 chk({tag, " R11 bs0"}, {16'h0, rd_o}, {16'h0, m_b0});
    sel = 2'd2; #1 chk({tag, " R11 bs1"}, {16'h0, rd_o}, {16'h0, m_b1});
    sel = 2'd3; #1 chk({tag, " R11 sel3"}, {16'h0, rd_o}, 32'h0000_FFFF);
  endtask

  // one access cycle; optional clear in same cycle
  task automatic access(input logic v, input logic [23:0] a, input logic w, input logic [1:0] sz,
                        input logic su, input logic d, input logic [1:0] s, input logic e,
                        input logic en, input logic p, input logic c, input logic [31:0] md);
    logic [2:0] ec;
    logic       ef;
    @(negedge clk);
    valid = v; addr = a; wr = w; size = sz; sup = su; dma = d; st = s; we = e;
    een = en; pie = p; clr = c; mrd = md;
    ec = ref_cause(a, s, w, su, e);
    ef = v && (ec != 3'd0);
    #1;
    chk("R2/R3/R4 cause", {29'h0, cause_o}, {29'h0, ec});
    chk("R10 mem_we", {31'h0, mwe_o}, {31'h0, v && w && !ef});
    chk("R10 rdata", crd_o, (ef && !w) ? 32'hFFFF_FFFF : md);
    if (ef) begin
      m_gs = ref_gs(ec, d, w, p);               // R5
      m_b0 = ref_b0(d, sz, a);                  // R6
      m_b1 = a[15:0];                           // R7
    end else if (c) begin
      m_gs = 16'hFFFF; m_b0 = 16'hFFFF; m_b1 = 16'hFFFF; // R9
    end                                         // else R12 hold
    @(posedge clk); #1;
    valid = 1'b0; clr = 1'b0;
    chk("R8 bus_err", {31'h0, berr_o}, {31'h0, ef && en && !d});
    chk("R8 nmi", {31'h0, nmi_o}, {31'h0, ef && en && d});
    read_back(c ? "R9" : (ef ? "R5/R6/R7" : "R12"));
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] alist [6];
    int n;
    alist[0] = 24'h000123; alist[1] = 24'h0A5671; alist[2] = 24'h3FF00E;
    alist[3] = 24'h400002; alist[4] = 24'h8C1235; alist[5] = 24'hE4F00B;
    n = 0;
    #35;
    // R1 reset state
    chk("R1 bus_err", {31'h0, berr_o}, 32'h0);
    chk("R1 nmi", {31'h0, nmi_o}, 32'h0);
    read_back("R1");
    rst_n = 1'b1;
    for (int ai = 0; ai < 6; ai++)
      for (int s = 0; s < 4; s++)
        for (int x = 0; x < 16; x++)
          for (int z = 0; z < 3; z++) begin
            access(1'b1, alist[ai] ^ 24'(z), x[0], 2'(z), x[1], x[2], 2'(s), x[3],
                   (n % 3) != 0, (n % 5) < 2, 1'b0, 32'h1234_5678 ^ 32'(n));
            n++;
          end
    // R9 clear alone, clear with allowed access, clear with fault
    access(1'b0, 24'h0, 1'b0, 2'd1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    access(1'b1, 24'h3FF00E, 1'b1, 2'd0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0);
    access(1'b1, 24'h1ABCDF, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0);
    access(1'b1, 24'h2C0001, 1'b0, 2'd0, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 32'hA5A5_5A5A);
    // R12 idle cycle with no clear keeps state
    access(1'b1, 24'h500000, 1'b0, 2'd2, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    access(1'b0, 24'h000000, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule